// File: doc/BRIEF.md
# I2C Line Conditioner

This block sits between the SCL and SDA input pads and the I2C slave protocol logic. It runs entirely in one system clock domain. Each line first passes through a multi-flop synchroniser. A small per-line qualification state machine then accepts a new level only after the synchronised line has held that level for `MIN_PULSE` consecutive clocks. Any shorter excursion is discarded without ever appearing downstream. `MIN_PULSE` should be chosen so that that many clock periods cover at least 50 ns.

The filtered SDA then goes through a further `HOLD_DLY`-stage delay, while the filtered SCL is passed on directly. This gives the downstream START/STOP detector an internal hold time. An SDA change that lands close to a falling SCL edge is therefore seen only after SCL has dropped, and cannot be mistaken for a START or STOP. `HOLD_DLY` should cover about 120 ns and must stay below the 260 ns minimum START hold time, or a genuine START would be lost. A hold of this length suits fast-mode-plus timing only; it does not give the longer hold that standard and fast mode would need.

Each qualifier has four states. `DG_HIGH` and `DG_LOW` are the settled levels. `DG_QUAL_LOW` and `DG_QUAL_HIGH` count a candidate new level. The transitions are:

- *drop*: `DG_HIGH` to `DG_QUAL_LOW` on a low sample.
- *reject-low*: `DG_QUAL_LOW` back to `DG_HIGH` on a high sample.
- *accept-low*: `DG_QUAL_LOW` to `DG_LOW` on the `MIN_PULSE`-th consecutive low sample.
- *rise*, *reject-high* and *accept-high*: the mirror transitions out of `DG_LOW` and `DG_QUAL_HIGH`.

The output is high in `DG_HIGH` and `DG_QUAL_LOW`, and low otherwise.

Top module: `i2c_line_conditioner`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `scl_o` and `sda_o` are both 1 (idle bus), whatever the inputs do during reset.
- R2: An SCL excursion that lasts fewer than `MIN_PULSE` sampled clocks never reaches `scl_o`. This includes two sub-minimum excursions separated by a single opposite sample, because qualification restarts from zero.
- R3: An SDA excursion that lasts fewer than `MIN_PULSE` sampled clocks never reaches `sda_o`.
- R4: An accepted SCL level appears on `scl_o` exactly `SYNC_STAGES + MIN_PULSE - 1` clocks after the clock edge that first samples it on `scl_i`.
- R5: A pulse of at least `MIN_PULSE` clocks, including one of exactly `MIN_PULSE`, leaves the block with its width unchanged.
- R6: An accepted SDA level appears on `sda_o` exactly `SYNC_STAGES + MIN_PULSE - 1 + HOLD_DLY` clocks after the edge that first samples it on `sda_i`.
- R7: When SCL and SDA change in the same input cycle, `sda_o` changes exactly `HOLD_DLY` clocks after `scl_o`.
- R8: An SDA change placed up to `HOLD_DLY - 1` clocks ahead of an SCL fall shows no START (SDA falling while SCL stays high) and no STOP (SDA rising while SCL stays high) on the outputs. A lead of `HOLD_DLY + 1` clocks does show one.
- R9: An SDA fall followed 26 or more clocks later by an SCL fall gives exactly one START on the outputs. An SCL rise followed 26 or more clocks later by an SDA rise gives exactly one STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| scl_o | output | 1 | Synchronised, glitch-filtered SCL |
| sda_o | output | 1 | Synchronised, glitch-filtered, hold-delayed SDA |

## Verification
The two functions that can coincide are SCL qualification and SDA qualification plus hold delay. An SCL edge and an SDA edge can emerge from their filters in the same cycle. The bench provokes this by switching both inputs in one cycle, and by leading an SCL fall with an SDA change by a few cycles, both just inside and just outside the hold window. It judges the result by counting START and STOP patterns on the output pair and by measuring the output edge spacing, alongside a per-cycle behavioural reference model of both lines.

// File: rtl/i2c_cond_pkg.sv
`timescale 1ns/1ps
package i2c_cond_pkg;

    // Qualification state of one filtered line
    typedef enum logic [1:0] {
        DG_HIGH      = 2'b00,
        DG_QUAL_LOW  = 2'b01,
        DG_LOW       = 2'b10,
        DG_QUAL_HIGH = 2'b11
    } dg_state_t;

    // Lane indices inside the conditioner
    localparam int LANE_SCL = 0;
    localparam int LANE_SDA = 1;
    localparam int NUM_LANES = 2;

endpackage

// File: rtl/i2c_cond_sync.sv
`timescale 1ns/1ps
module i2c_cond_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Preset to 1 so the idle bus level is seen from reset onwards
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_cond_deglitch.sv
`timescale 1ns/1ps
module i2c_cond_deglitch
    import i2c_cond_pkg::*;
#(
    parameter int MIN_PULSE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_PULSE - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    dg_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             level;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DG_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: drop / reject / accept transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DG_HIGH: begin
                if (!din) begin
                    state_d = DG_QUAL_LOW;
                    cnt_d   = ONE_CNT;
                end
            end
            DG_QUAL_LOW: begin
                if (din) begin
                    state_d = DG_HIGH;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = DG_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE_CNT;
                end
            end
            DG_LOW: begin
                if (din) begin
                    state_d = DG_QUAL_HIGH;
                    cnt_d   = ONE_CNT;
                end
            end
            DG_QUAL_HIGH: begin
                if (!din) begin
                    state_d = DG_LOW;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = DG_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE_CNT;
                end
            end
            default: begin
                state_d = DG_HIGH;
                cnt_d   = '0;
            end
        endcase
    end

    // Output: settled level, held during qualification of the opposite one
    always_comb begin
        unique case (state_q)
            DG_HIGH, DG_QUAL_LOW:  level = 1'b1;
            DG_LOW,  DG_QUAL_HIGH: level = 1'b0;
            default:               level = 1'b1;
        endcase
    end

    assign dout = level;

endmodule

// File: rtl/i2c_cond_delay.sv
`timescale 1ns/1ps
module i2c_cond_delay #(
    parameter int DEPTH = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [DEPTH-1:0] stages;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stages <= '1;
                else        stages <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stages <= '1;
                else        stages <= {stages[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = stages[DEPTH-1];

endmodule

// File: rtl/i2c_line_conditioner.sv
`timescale 1ns/1ps
module i2c_line_conditioner
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 5,
    parameter int HOLD_DLY    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o
);

    logic [NUM_LANES-1:0] raw;
    logic [NUM_LANES-1:0] synced;
    logic [NUM_LANES-1:0] clean;
    logic [NUM_LANES-1:0] lane_out;

    assign raw[LANE_SCL] = scl_i;
    assign raw[LANE_SDA] = sda_i;

    generate
        for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
            i2c_cond_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw[ln]),
                .q     (synced[ln])
            );

            i2c_cond_deglitch #(.MIN_PULSE(MIN_PULSE)) u_dg (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (synced[ln]),
                .dout  (clean[ln])
            );

            if (ln == LANE_SDA) begin : g_hold
                i2c_cond_delay #(.DEPTH(HOLD_DLY)) u_hold (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .d     (clean[ln]),
                    .q     (lane_out[ln])
                );
            end else begin : g_direct
                assign lane_out[ln] = clean[ln];
            end
        end
    endgenerate

    assign scl_o = lane_out[LANE_SCL];
    assign sda_o = lane_out[LANE_SDA];

endmodule

// File: rtl/i2c_cond_checker.sv
`timescale 1ns/1ps
module i2c_cond_checker #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 5,
    parameter int HOLD_DLY    = 12
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic scl_o,
    input logic sda_o
);

    localparam int LAT = SYNC_STAGES + MIN_PULSE - 1;
    localparam int CAP = LAT + HOLD_DLY + 1;
    localparam int CW  = $clog2(CAP + 1) + 1;
    localparam logic [CW-1:0] CAP_V = CW'(CAP);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    logic          scl_prev, sda_prev, scl_raw_prev, sda_raw_prev;
    logic [CW-1:0] scl_run, sda_run, scl_age, sda_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev     <= 1'b1;
            sda_prev     <= 1'b1;
            scl_raw_prev <= 1'b1;
            sda_raw_prev <= 1'b1;
            scl_run      <= '0;
            sda_run      <= '0;
            scl_age      <= CAP_V;
            sda_age      <= CAP_V;
        end else begin
            scl_prev     <= scl_o;
            sda_prev     <= sda_o;
            scl_raw_prev <= scl_i;
            sda_raw_prev <= sda_i;
            scl_run <= (scl_o != scl_prev) ? ONE_V : ((scl_run == CAP_V) ? scl_run : scl_run + ONE_V);
            sda_run <= (sda_o != sda_prev) ? ONE_V : ((sda_run == CAP_V) ? sda_run : sda_run + ONE_V);
            scl_age <= (scl_i != scl_raw_prev) ? '0 : ((scl_age == CAP_V) ? scl_age : scl_age + ONE_V);
            sda_age <= (sda_i != sda_raw_prev) ? '0 : ((sda_age == CAP_V) ? sda_age : sda_age + ONE_V);
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> (scl_o && sda_o)); // R1
    AST_SCL_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n) (scl_o != scl_prev) |-> (scl_run >= CW'(MIN_PULSE))); // R2
    AST_SDA_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n) (sda_o != sda_prev) |-> (sda_run >= CW'(MIN_PULSE))); // R3
    AST_SCL_CAUSED: assert property (@(posedge clk) disable iff (!rst_n) (scl_o != scl_prev) |-> (scl_age <= CW'(LAT))); // R4
    AST_SDA_CAUSED: assert property (@(posedge clk) disable iff (!rst_n) (sda_o != sda_prev) |-> (sda_age <= CW'(LAT + HOLD_DLY))); // R6

endmodule

bind i2c_line_conditioner i2c_cond_checker #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_PULSE   (MIN_PULSE),
    .HOLD_DLY    (HOLD_DLY)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .scl_o (scl_o),
    .sda_o (sda_o)
);

// File: tb/sim_i2c_line_conditioner.sv
`timescale 1ns/1ps
module sim_i2c_line_conditioner;

    localparam int SYNC = 2;
    localparam int NP   = 5;
    localparam int HD   = 12;
    localparam int LAT  = SYNC + NP - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic scl_o, sda_o;

    i2c_line_conditioner #(.SYNC_STAGES(SYNC), .MIN_PULSE(NP), .HOLD_DLY(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit armed  = 1'b0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, stepped on each rising edge
    bit sq_scl[$], sq_sda[$], dq[$];
    int run_scl, run_sda;
    bit m_scl = 1'b1, m_sda = 1'b1, m_sda_o = 1'b1;
    int cyc = 0;
    bit raw_scl_prev = 1'b1, raw_sda_prev = 1'b1;
    int t_scl_in, t_sda_in;

    always @(posedge clk) begin
        bit s_scl, s_sda;
        cyc++;
        if (scl_i != raw_scl_prev) t_scl_in = cyc;
        if (sda_i != raw_sda_prev) t_sda_in = cyc;
        raw_scl_prev = scl_i;
        raw_sda_prev = sda_i;
        if (!rst_n) begin
            sq_scl.delete(); sq_sda.delete(); dq.delete();
            for (int i = 0; i < SYNC; i++) begin sq_scl.push_back(1'b1); sq_sda.push_back(1'b1); end
            for (int i = 0; i < HD; i++) dq.push_back(1'b1);
            run_scl = 0; run_sda = 0;
            m_scl = 1'b1; m_sda = 1'b1; m_sda_o = 1'b1;
        end else begin
            s_scl = sq_scl.pop_front(); sq_scl.push_back(scl_i);
            s_sda = sq_sda.pop_front(); sq_sda.push_back(sda_i);
            if (s_scl == m_scl) run_scl = 0;
            else begin run_scl++; if (run_scl == NP) begin m_scl = s_scl; run_scl = 0; end end
            if (s_sda == m_sda) run_sda = 0;
            else begin run_sda++; if (run_sda == NP) begin m_sda = s_sda; run_sda = 0; end end
            m_sda_o = dq.pop_front();
            dq.push_back(m_sda);
        end
    end

    // Output monitor on falling edges
    bit prev_scl = 1'b1, prev_sda = 1'b1;
    int n_scl_fall = 0, n_sda_fall = 0, n_start = 0, n_stop = 0;
    int low_scl = 0, low_sda = 0, w_scl_low = 0, w_sda_low = 0;
    int t_scl_out_fall = 0, t_sda_out_fall = 0;

    always @(negedge clk) begin
        if (rst_n && armed) begin
            check("R4", "scl_o vs model", int'(scl_o), int'(m_scl));
            check("R6", "sda_o vs model", int'(sda_o), int'(m_sda_o));
        end
        if (prev_scl && !scl_o) begin n_scl_fall++; t_scl_out_fall = cyc; end
        if (prev_sda && !sda_o) begin n_sda_fall++; t_sda_out_fall = cyc; end
        if (!prev_scl && scl_o) w_scl_low = low_scl;
        if (!prev_sda && sda_o) w_sda_low = low_sda;
        low_scl = scl_o ? 0 : low_scl + 1;
        low_sda = sda_o ? 0 : low_sda + 1;
        if (prev_scl && scl_o && prev_sda && !sda_o) n_start++;
        if (prev_scl && scl_o && !prev_sda && sda_o) n_stop++;
        prev_scl = scl_o;
        prev_sda = sda_o;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_scl(int w);
        scl_i = 1'b0; tick(w); scl_i = 1'b1; tick(20);
    endtask

    task automatic pulse_sda(int w);
        sda_i = 1'b0; tick(w); sda_i = 1'b1; tick(20);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int s0, s1;
        // R1: idle high during reset, even with inputs low
        tick(3);
        scl_i = 1'b0; sda_i = 1'b0;
        tick(10);
        check("R1", "scl_o in reset", int'(scl_o), 1);
        check("R1", "sda_o in reset", int'(sda_o), 1);
        scl_i = 1'b1; sda_i = 1'b1;
        tick(4);
        rst_n = 1'b1; armed = 1'b1;
        tick(1);
        check("R1", "scl_o after release", int'(scl_o), 1);
        check("R1", "sda_o after release", int'(sda_o), 1);
        tick(30);

        // R2: short and interrupted SCL excursions rejected
        s0 = n_scl_fall;
        pulse_scl(1);
        pulse_scl(NP - 1);
        scl_i = 1'b0; tick(NP - 1); scl_i = 1'b1; tick(1); scl_i = 1'b0; tick(NP - 1); scl_i = 1'b1; tick(20);
        check("R2", "scl_o falls after glitches", n_scl_fall - s0, 0);

        // R3: short SDA excursions rejected
        s0 = n_sda_fall; s1 = n_start;
        pulse_sda(1);
        pulse_sda(NP - 1);
        tick(20);
        check("R3", "sda_o falls after glitches", n_sda_fall - s0, 0);
        check("R3", "START from sda glitches", n_start - s1, 0);

        // R5: boundary and long pulses keep their width
        s0 = n_scl_fall;
        pulse_scl(NP);
        check("R5", "exact-minimum scl pulse passes", n_scl_fall - s0, 1);
        check("R5", "exact-minimum scl width", w_scl_low, NP);
        pulse_scl(3 * NP);
        check("R5", "long scl width", w_scl_low, 3 * NP);
        pulse_sda(NP + 2);
        tick(HD + 5);
        check("R5", "sda width", w_sda_low, NP + 2);

        // R4: SCL latency
        scl_i = 1'b0; tick(30);
        check("R4", "scl latency", t_scl_out_fall - t_scl_in, LAT);
        scl_i = 1'b1; tick(30);

        // R6: SDA latency
        sda_i = 1'b0; tick(40);
        check("R6", "sda latency", t_sda_out_fall - t_sda_in, LAT + HD);
        sda_i = 1'b1; tick(40);

        // R7 and R8: both lines change in the same cycle
        s1 = n_start;
        scl_i = 1'b0; sda_i = 1'b0; tick(40);
        check("R7", "sda_o lag behind scl_o", t_sda_out_fall - t_scl_out_fall, HD);
        check("R8", "START on same-cycle change", n_start - s1, 0);
        sda_i = 1'b1; tick(10); scl_i = 1'b1; tick(30);

        // R8: SDA rise 3 cycles before SCL fall, no STOP
        sda_i = 1'b0; tick(40);
        s0 = n_stop; s1 = n_start;
        sda_i = 1'b1; tick(3); scl_i = 1'b0; tick(40);
        check("R8", "STOP with short SDA lead", n_stop - s0, 0);
        check("R8", "START with short SDA lead", n_start - s1, 0);
        scl_i = 1'b1; tick(40);

        // R8: SDA fall HD-1 cycles before SCL fall, no START
        s1 = n_start;
        sda_i = 1'b0; tick(HD - 1); scl_i = 1'b0; tick(40);
        check("R8", "START with lead HD-1", n_start - s1, 0);
        sda_i = 1'b1; tick(10); scl_i = 1'b1; tick(40);

        // R8: SDA fall HD+1 cycles before SCL fall, START visible
        s1 = n_start;
        sda_i = 1'b0; tick(HD + 1); scl_i = 1'b0; tick(40);
        check("R8", "START with lead HD+1", n_start - s1, 1);
        sda_i = 1'b1; tick(10); scl_i = 1'b1; tick(40);

        // R9: genuine START and STOP with 26-cycle spacing
        s1 = n_start;
        sda_i = 1'b0; tick(26); scl_i = 1'b0; tick(40);
        check("R9", "genuine START", n_start - s1, 1);
        s0 = n_stop;
        scl_i = 1'b1; tick(26); sda_i = 1'b1; tick(40);
        check("R9", "genuine STOP", n_stop - s0, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule